// File: doc/BRIEF.md
# Oversampling Serial Receiver with Two-Entry Buffer and Flush

This block recovers asynchronous serial characters from a single line. An external enable pulses once per sample period, and each bit lasts sixteen samples. A line low in idle starts a frame, which has a start bit, five to nine data bits sent least significant bit first, an optional parity bit and one stop bit. The block decides each bit from three samples around the middle of the bit.

Each finished character goes into a two-entry first-in first-out buffer. Each entry carries its own frame, parity and overrun flags. The consumer reads the oldest entry from the output pins. The ninth data bit sits on a separate pin and must be captured before the read strobe is pulsed, because that strobe removes the whole entry.

A receive-enable input switches the block on and shows on an output that the receiver now owns the line. When the enable is cleared, the buffer and every flag it holds are thrown away, and any frame in progress is dropped.

Top module: `srx_top`

## Requirements
- R1: After reset, and whenever the buffer is empty, `rd_valid` is 0 and `rd_data`, `rd_bit8`, `rd_ferr`, `rd_perr` and `rd_ovr` are all 0.
- R2: `rx_claim` equals `rx_en` at all times.
- R3: `char_size` sets the number of data bits: 000=5, 001=6, 010=7, 011=8, 111=9, and any other code gives 8. The data bits arrive least significant bit first and are stored right-aligned. Stored bits above the character size read 0.
- R4: In nine-bit mode the ninth data bit appears on `rd_bit8`, together with the low byte of the same entry. A pop moves both to the next entry.
- R5: `parity_mode` 00 or 01 means no parity bit, 10 means even parity and 11 means odd parity. With parity on, the received parity bit is compared with the parity computed over the data bits. A mismatch sets `rd_perr` of that entry.
- R6: Only one stop bit is checked. A stop bit decided low sets `rd_ferr` of that entry. A new start bit may follow directly after a single high stop bit.
- R7: Each bit value is the majority of samples 7, 8 and 9 of its 16 samples. One flipped sample inside that window does not change the result.
- R8: A start bit whose majority at mid-bit is high is dropped, and nothing is stored.
- R9: The buffer holds up to two entries in arrival order. A one-cycle `rd_pop` removes the oldest entry. A pop on an empty buffer has no effect.
- R10: A frame that completes while two entries are stored, with no pop in that cycle, is thrown away and sets `rd_ovr` of the newest stored entry.
- R11: While `rx_en` is 0, the buffer is emptied within one cycle, all stored flags are lost and no frame is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_tick | input | 1 | One-cycle pulse per sample period (16 per bit) |
| rx_en | input | 1 | Receiver on; 0 flushes the buffer |
| char_size | input | 3 | Character size code |
| parity_mode | input | 2 | Parity off / even / odd |
| rx_pin | input | 1 | Serial line, idle high |
| rx_claim | output | 1 | Receiver owns the line |
| rd_pop | input | 1 | Read strobe that removes the oldest entry |
| rd_data | output | 8 | Low data byte of the oldest entry |
| rd_bit8 | output | 1 | Ninth data bit of the oldest entry |
| rd_valid | output | 1 | At least one entry stored |
| rd_ferr | output | 1 | Frame error of the oldest entry |
| rd_perr | output | 1 | Parity error of the oldest entry |
| rd_ovr | output | 1 | Overrun marker of the oldest entry |

## Verification
The assertions assume that `rd_pop` is a single-cycle pulse. They also assume that `char_size` and `parity_mode` do not change while a frame is being received, because the block reads them live at the stop-bit decision. The stimulus changes the configuration only while the line is idle, and it holds every bit for exactly sixteen sample pulses. A single flipped sample near mid-bit, a short low pulse that imitates a start bit, and a stop bit driven low are the only ways the bench breaks the frame timing.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int unsigned SRX_MAXW = 9;

  typedef struct packed {
    logic [SRX_MAXW-1:0] data;
    logic                ferr;
    logic                perr;
    logic                ovr;
  } srx_entry_t;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP
  } srx_state_e;

  // character-size code to number of data bits
  function automatic logic [3:0] data_bits(input logic [2:0] sz);
    case (sz)
      3'b000:  return 4'd5;
      3'b001:  return 4'd6;
      3'b010:  return 4'd7;
      3'b111:  return 4'd9;
      default: return 4'd8;
    endcase
  endfunction

  function automatic logic vote3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction

  // bits enter at the top; shift down so the first bit lands at bit 0
  function automatic logic [SRX_MAXW-1:0] align_lsb(input logic [SRX_MAXW-1:0] sh,
                                                     input logic [3:0] nb);
    return sh >> (4'(SRX_MAXW) - nb);
  endfunction

  function automatic logic parity_ref(input logic [SRX_MAXW-1:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (!rst_n) sr <= '1;
    else        sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/srx_frame.sv
module srx_frame
  import srx_pkg::*;
#(
  parameter int unsigned OSR     = 16,
  parameter int unsigned VOTE_LO = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       enable,
  input  logic       rx,
  input  logic [2:0] char_sz,
  input  logic [1:0] par_mode,
  output logic       push_o,
  output srx_entry_t entry_o,
  output logic       idle_o
);
  localparam int unsigned CNT_W = $clog2(OSR + 1);
  localparam int unsigned MID   = VOTE_LO + 2;
  localparam logic [CNT_W-1:0] C_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] C_TWO = CNT_W'(2);
  localparam logic [CNT_W-1:0] C_LO  = CNT_W'(VOTE_LO);
  localparam logic [CNT_W-1:0] C_MID = CNT_W'(MID);
  localparam logic [CNT_W-1:0] C_OSR = CNT_W'(OSR);

  srx_state_e          state;
  logic [CNT_W-1:0]    cnt;     // index of the sample taken at the next tick
  logic [2:0]          samp;
  logic [SRX_MAXW-1:0] shreg;
  logic [3:0]          nbit;
  logic                parbit;

  logic [2:0]          samp_n;
  logic                bitv;
  logic [3:0]          nb;
  logic                par_en;
  logic [SRX_MAXW-1:0] dalign;

  always_comb begin
    samp_n = ((cnt >= C_LO) && (cnt <= C_MID)) ? {samp[1:0], rx} : samp;
    bitv   = vote3(samp_n);
    nb     = data_bits(char_sz);
    par_en = par_mode[1];
    dalign = align_lsb(shreg, nb);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      samp    <= '0;
      shreg   <= '0;
      nbit    <= '0;
      parbit  <= 1'b0;
      push_o  <= 1'b0;
      entry_o <= '0;
    end else begin
      push_o <= 1'b0;
      if (!enable) begin
        state <= S_IDLE;
      end else if (tick) begin
        samp <= samp_n;
        cnt  <= (cnt == C_OSR) ? C_ONE : cnt + C_ONE;
        unique case (state)
          S_IDLE: if (!rx) begin
            state <= S_START;
            cnt   <= C_TWO;
            samp  <= '0;
          end
          S_START: begin
            if (cnt == C_MID && bitv) state <= S_IDLE;
            else if (cnt == C_OSR) begin
              state <= S_DATA;
              nbit  <= '0;
            end
          end
          S_DATA: begin
            if (cnt == C_MID) shreg <= {bitv, shreg[SRX_MAXW-1:1]};
            if (cnt == C_OSR) begin
              if (nbit == nb - 4'd1) state <= par_en ? S_PAR : S_STOP;
              nbit <= nbit + 4'd1;
            end
          end
          S_PAR: begin
            if (cnt == C_MID) parbit <= bitv;
            if (cnt == C_OSR) state <= S_STOP;
          end
          S_STOP: if (cnt == C_MID) begin
            push_o       <= 1'b1;
            entry_o.data <= dalign;
            entry_o.ferr <= !bitv;
            entry_o.perr <= par_en && (parbit != parity_ref(dalign, par_mode[0]));
            entry_o.ovr  <= 1'b0;
            state        <= S_IDLE;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assign idle_o = (state == S_IDLE);
endmodule

// File: rtl/srx_rxbuf.sv
module srx_rxbuf
  import srx_pkg::*;
#(
  parameter int unsigned DEPTH = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  srx_entry_t                 din,
  input  logic                       pop,
  output srx_entry_t                 head_o,
  output logic [$clog2(DEPTH+1)-1:0] fill_o,
  output logic                       ovr_o
);
  localparam int unsigned FILL_W = $clog2(DEPTH + 1);
  localparam int unsigned IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  srx_entry_t        mem   [DEPTH];
  srx_entry_t        mem_n [DEPTH];
  logic [FILL_W-1:0] fill, fill_n, base;
  logic              do_pop, accept;

  always_comb begin
    do_pop = pop && (fill != '0);
    base   = fill - FILL_W'(do_pop);
    accept = push && (base < FILL_W'(DEPTH));
    ovr_o  = push && !(base < FILL_W'(DEPTH));
    for (int i = 0; i < DEPTH - 1; i++) mem_n[i] = do_pop ? mem[i+1] : mem[i];
    mem_n[DEPTH-1] = do_pop ? '0 : mem[DEPTH-1];
    if (accept) mem_n[IDX_W'(base)] = din;
    if (ovr_o)  mem_n[DEPTH-1].ovr = 1'b1;
    fill_n = base + FILL_W'(accept);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      fill <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      fill <= fill_n;
      for (int i = 0; i < DEPTH; i++) mem[i] <= mem_n[i];
    end
  end

  assign head_o = (fill != '0) ? mem[0] : '0;
  assign fill_o = fill;
endmodule

// File: rtl/srx_top.sv
module srx_top
  import srx_pkg::*;
#(
  parameter int unsigned OSR         = 16,
  parameter int unsigned VOTE_LO     = 7,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DEPTH       = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sample_tick,
  input  logic       rx_en,
  input  logic [2:0] char_size,
  input  logic [1:0] parity_mode,
  input  logic       rx_pin,
  output logic       rx_claim,
  input  logic       rd_pop,
  output logic [7:0] rd_data,
  output logic       rd_bit8,
  output logic       rd_valid,
  output logic       rd_ferr,
  output logic       rd_perr,
  output logic       rd_ovr
);
  localparam int unsigned FILL_W = $clog2(DEPTH + 1);

  logic              rx_s;
  logic              frm_push;
  srx_entry_t        frm_entry;
  logic              frm_idle;
  srx_entry_t        head;
  logic [FILL_W-1:0] buf_fill;
  logic              buf_ovr;

  srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rx_pin), .q(rx_s)
  );

  srx_frame #(.OSR(OSR), .VOTE_LO(VOTE_LO)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick(sample_tick), .enable(rx_en), .rx(rx_s),
    .char_sz(char_size), .par_mode(parity_mode),
    .push_o(frm_push), .entry_o(frm_entry), .idle_o(frm_idle)
  );

  srx_rxbuf #(.DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n), .flush(!rx_en), .push(frm_push), .din(frm_entry),
    .pop(rd_pop), .head_o(head), .fill_o(buf_fill), .ovr_o(buf_ovr)
  );

  assign rx_claim = rx_en;
  assign rd_valid = (buf_fill != '0);
  assign rd_data  = head.data[7:0];
  assign rd_bit8  = head.data[8];
  assign rd_ferr  = head.ferr;
  assign rd_perr  = head.perr;
  assign rd_ovr   = head.ovr;
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
  parameter int unsigned DEPTH = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       rx_en,
  input logic                       rd_pop,
  input logic                       rd_valid,
  input logic [7:0]                 rd_data,
  input logic                       rd_bit8,
  input logic                       rd_ferr,
  input logic                       rd_perr,
  input logic                       rd_ovr,
  input logic                       frm_push,
  input logic                       frm_idle,
  input logic                       buf_ovr,
  input logic [$clog2(DEPTH+1)-1:0] buf_fill
);
  p_empty_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (rd_data == 8'h00 && !rd_bit8 && !rd_ferr && !rd_perr && !rd_ovr));

  p_fill_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    buf_fill <= ($clog2(DEPTH+1))'(DEPTH));

  p_push_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && frm_push && buf_fill == '0) |=> rd_valid);

  p_pop_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && rd_pop && rd_valid && !frm_push) |=> (buf_fill == $past(buf_fill) - 1'b1));

  p_overrun_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && buf_ovr) |=> (buf_fill == ($clog2(DEPTH+1))'(DEPTH) && rd_valid));

  p_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (buf_fill == '0 && !rd_valid));

  p_halt_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> frm_idle);
endmodule

bind srx_top srx_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rd_pop(rd_pop), .rd_valid(rd_valid),
  .rd_data(rd_data), .rd_bit8(rd_bit8), .rd_ferr(rd_ferr), .rd_perr(rd_perr),
  .rd_ovr(rd_ovr), .frm_push(frm_push), .frm_idle(frm_idle), .buf_ovr(buf_ovr),
  .buf_fill(buf_fill)
);

// File: tb/srx_top_tb_top.sv
`timescale 1ns/1ps
module srx_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sample_tick = 1'b0;
  logic       rx_en = 1'b0;
  logic [2:0] char_size = 3'b011;
  logic [1:0] parity_mode = 2'b00;
  logic       rx_line = 1'b1;
  logic       rd_pop = 1'b0;
  logic       rx_claim, rd_bit8, rd_valid, rd_ferr, rd_perr, rd_ovr;
  logic [7:0] rd_data;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;  // 200 MHz

  srx_top dut_i (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .rx_en(rx_en),
    .char_size(char_size), .parity_mode(parity_mode), .rx_pin(rx_line),
    .rx_claim(rx_claim), .rd_pop(rd_pop), .rd_data(rd_data), .rd_bit8(rd_bit8),
    .rd_valid(rd_valid), .rd_ferr(rd_ferr), .rd_perr(rd_perr), .rd_ovr(rd_ovr)
  );

  // one sample pulse every 4 clocks
  int tcnt = 0;
  always @(negedge clk) begin
    tcnt        = (tcnt + 1) % 4;
    sample_tick = (tcnt == 0);
  end

  // ---------------- behavioural reference model ----------------
  typedef struct {
    int unsigned data;
    bit fe, pe, ov;
  } ent_t;

  ent_t q[$];
  bit   pend;
  ent_t pend_e;
  int   m_s1 = 1, m_s2 = 1;
  int   mst = 0, mcnt = 0, votes = 0, got = 0, pbit = 0;
  int unsigned dval = 0;

  function automatic int size_of(input logic [2:0] c);
    if (c == 3'b000) return 5;
    if (c == 3'b001) return 6;
    if (c == 3'b010) return 7;
    if (c == 3'b111) return 9;
    return 8;
  endfunction

  function automatic int ones(input int unsigned v);
    int n = 0;
    for (int i = 0; i < 32; i++) n += (v >> i) & 1;
    return n;
  endfunction

  always @(posedge clk) begin
    int s_old, idx, val;
    s_old = m_s2;
    val   = 0;
    if (!rst_n) begin
      q.delete(); pend = 0; mst = 0; m_s1 = 1; m_s2 = 1;
    end else begin
      if (!rx_en) q.delete();
      else begin
        if (rd_pop && q.size() > 0) void'(q.pop_front());
        if (pend) begin
          if (q.size() < 2) q.push_back(pend_e);
          else q[q.size()-1].ov = 1;
        end
      end
      pend = 0;
      if (!rx_en) mst = 0;
      else if (sample_tick) begin
        if (mst == 0) begin
          if (s_old == 0) begin mst = 1; mcnt = 2; votes = 0; end
        end else begin
          idx  = mcnt;
          mcnt = (idx == 16) ? 1 : idx + 1;
          if (idx >= 7 && idx <= 9) votes += s_old;
          if (idx == 9) val = (votes >= 2);
          case (mst)
            1: if (idx == 9 && val) mst = 0;
               else if (idx == 16) begin mst = 2; got = 0; dval = 0; end
            2: begin
                 if (idx == 9) begin dval |= (val << got); got++; end
                 if (idx == 16 && got == size_of(char_size)) mst = parity_mode[1] ? 3 : 4;
               end
            3: begin
                 if (idx == 9) pbit = val;
                 if (idx == 16) mst = 4;
               end
            default: if (idx == 9) begin
                 pend        = 1;
                 pend_e.data = dval;
                 pend_e.fe   = (val == 0);
                 pend_e.pe   = parity_mode[1] &&
                               (pbit != ((ones(dval) % 2) ^ int'(parity_mode[0])));
                 pend_e.ov   = 0;
                 mst         = 0;
               end
          endcase
          if (idx == 16) votes = 0;
        end
      end
      m_s2 = m_s1;
      m_s1 = int'(rx_line);
    end
  end

  // compare model and design on every clock
  always @(posedge clk) begin
    logic [13:0] act, exp;
    #1;
    if (rst_n && !done) begin
      act = {rx_claim, rd_valid, rd_bit8, rd_ferr, rd_perr, rd_ovr, rd_data};
      if (q.size() > 0)
        exp = {rx_en, 1'b1, q[0].data[8], q[0].fe, q[0].pe, q[0].ov, q[0].data[7:0]};
      else
        exp = {rx_en, 13'h0};
      n_tests++;
      if (act !== exp) begin
        n_fail++;
        $display("FAIL %s model compare: actual=%h expected=%h", cur_req, act, exp);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input bit v, input bit glitch);
    for (int c = 0; c < 64; c++) begin
      rx_line = (glitch && c >= 28 && c < 32) ? !v : v;
      @(negedge clk);
    end
  endtask

  task automatic send_frame(input int unsigned val, input bit stop_v, input bit pflip,
                            input int gap_bits, input int glitch_bit);
    int  nb;
    bit  p;
    nb = size_of(char_size);
    drive_bit(1'b0, 1'b0);
    for (int i = 0; i < nb; i++) drive_bit(val[i], glitch_bit == i);
    if (parity_mode[1]) begin
      p = ((ones(val & ((1 << nb) - 1)) % 2) != 0) ^ parity_mode[0] ^ pflip;
      drive_bit(p, 1'b0);
    end
    drive_bit(stop_v, 1'b0);
    for (int g = 0; g < gap_bits; g++) drive_bit(1'b1, 1'b0);
  endtask

  task automatic pop();
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
    @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // ---------------- scenarios ----------------
  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R1";
    chk(!rd_valid && rd_data == 0 && !rd_ferr && !rd_perr && !rd_ovr && !rd_bit8,
        "R1 reset state", {rd_valid, rd_data}, 0);
    cur_req = "R2";
    chk(rx_claim == 1'b0, "R2 claim off", rx_claim, 0);
    rx_en = 1'b1;
    @(negedge clk);
    chk(rx_claim == 1'b1, "R2 claim on", rx_claim, 1);
    repeat (64) @(negedge clk);

    cur_req = "R3";
    send_frame(32'hA5, 1, 0, 1, -1);
    chk(rd_valid && rd_data == 8'hA5, "R3 eight bits", rd_data, 'hA5);
    pop();
    char_size = 3'b000;
    send_frame(32'hF5, 1, 0, 1, -1);
    chk(rd_data == 8'h15 && !rd_bit8, "R3 five bits", rd_data, 'h15);
    pop();
    char_size = 3'b001;
    send_frame(32'h2A, 1, 0, 1, -1);
    chk(rd_data == 8'h2A, "R3 six bits", rd_data, 'h2A);
    pop();
    char_size = 3'b010;
    send_frame(32'h5A, 1, 0, 1, -1);
    chk(rd_data == 8'h5A, "R3 seven bits", rd_data, 'h5A);
    pop();

    cur_req = "R4";
    char_size = 3'b111;
    send_frame(32'h1C3, 1, 0, 1, -1);
    send_frame(32'h055, 1, 0, 1, -1);
    chk(rd_bit8 == 1'b1 && rd_data == 8'hC3, "R4 ninth bit first entry",
        {rd_bit8, rd_data}, 'h1C3);
    pop();
    chk(rd_bit8 == 1'b0 && rd_data == 8'h55, "R4 ninth bit second entry",
        {rd_bit8, rd_data}, 'h055);
    pop();
    char_size = 3'b011;

    cur_req = "R5";
    parity_mode = 2'b10;
    send_frame(32'h3C, 1, 0, 1, -1);
    chk(rd_data == 8'h3C && !rd_perr, "R5 even match", rd_perr, 0);
    pop();
    send_frame(32'h3D, 1, 1, 1, -1);
    chk(rd_data == 8'h3D && rd_perr, "R5 even mismatch", rd_perr, 1);
    pop();
    parity_mode = 2'b11;
    send_frame(32'h81, 1, 0, 1, -1);
    chk(rd_data == 8'h81 && !rd_perr, "R5 odd match", rd_perr, 0);
    pop();
    send_frame(32'h07, 1, 1, 1, -1);
    chk(rd_data == 8'h07 && rd_perr, "R5 odd mismatch", rd_perr, 1);
    pop();
    parity_mode = 2'b00;

    cur_req = "R6";
    send_frame(32'h66, 0, 0, 2, -1);
    chk(rd_valid && rd_ferr && rd_data == 8'h66, "R6 stop low", rd_ferr, 1);
    pop();
    send_frame(32'h11, 1, 0, 0, -1);
    send_frame(32'h22, 1, 0, 1, -1);
    chk(rd_data == 8'h11 && !rd_ferr, "R6 back-to-back first", rd_data, 'h11);
    pop();
    chk(rd_data == 8'h22 && !rd_ferr, "R6 back-to-back second", rd_data, 'h22);
    pop();

    cur_req = "R7";
    send_frame(32'hF0, 1, 0, 1, 3);
    chk(rd_data == 8'hF0, "R7 glitch on zero bit", rd_data, 'hF0);
    pop();
    send_frame(32'h0F, 1, 0, 1, 2);
    chk(rd_data == 8'h0F, "R7 glitch on one bit", rd_data, 'h0F);
    pop();

    cur_req = "R8";
    rx_line = 1'b0;
    repeat (16) @(negedge clk);
    rx_line = 1'b1;
    repeat (160) @(negedge clk);
    chk(!rd_valid, "R8 false start dropped", rd_valid, 0);

    cur_req = "R9";
    pop();
    chk(!rd_valid && rd_data == 0, "R9 pop on empty", rd_valid, 0);
    cur_req = "R10";
    send_frame(32'h01, 1, 0, 1, -1);
    send_frame(32'h02, 1, 0, 1, -1);
    send_frame(32'h03, 1, 0, 1, -1);
    chk(rd_data == 8'h01 && !rd_ovr, "R9 oldest first", rd_data, 'h01);
    pop();
    chk(rd_data == 8'h02 && rd_ovr, "R10 overrun on newest", {rd_ovr, rd_data}, 'h102);
    pop();
    chk(!rd_valid, "R10 third frame discarded", rd_valid, 0);

    cur_req = "R11";
    parity_mode = 2'b10;
    send_frame(32'h44, 0, 1, 2, -1);
    send_frame(32'h45, 1, 0, 1, -1);
    chk(rd_valid && rd_ferr && rd_perr, "R11 flags before flush", {rd_ferr, rd_perr}, 3);
    rx_en = 1'b0;
    repeat (3) @(negedge clk);
    chk(!rd_valid && !rd_ferr && !rd_perr, "R11 flushed", {rd_valid, rd_ferr, rd_perr}, 0);
    rx_en = 1'b1;
    repeat (3) @(negedge clk);
    chk(!rd_valid, "R11 still empty after enable", rd_valid, 0);
    rx_en = 1'b0;
    send_frame(32'h99, 1, 0, 1, -1);
    rx_en = 1'b1;
    repeat (64) @(negedge clk);
    chk(!rd_valid, "R11 no reception while off", rd_valid, 0);
    parity_mode = 2'b00;

    cur_req = "R3";
    send_frame(32'hC7, 1, 0, 1, -1);
    chk(rd_data == 8'hC7 && !rd_ferr, "R3 receives again after re-enable", rd_data, 'hC7);
    pop();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule